// File: doc/BRIEF.md
# Multi-Window Overlay Pixel Compositor

This block merges up to five stacked overlay windows into one RGB pixel stream. A display timing generator supplies the current raster column and row and an active-pixel flag. Each window arrives with its pixel for that position on a parallel input, together with its configuration: a rectangle given by two inclusive corners, an enable, a pixel format code, a per-channel constant alpha, a per-pixel alpha select and a color-key compare. The block finds which enabled windows cover the raster position. It then composites them from the lowest index to the highest and registers the result. The output appears one clock after the coordinates are presented.

Window 0 is the opaque base layer. Its alpha and key settings are ignored, and a pixel carrying an alpha bit is shown as if the bit were absent. Windows 1 to 4 blend over whatever lies below them. Each uses its constant alpha or the pixel's own alpha bit, and a pixel can be made fully transparent by a key compare. A position that no enabled window covers comes out black.

Top module: `ovl_compositor`

## Requirements
- R1: `out_valid_o` equals `px_active_i` from one clock earlier. `out_rgb_o` is 0 whenever `out_valid_o` is 0. Both outputs are 0 while reset is held.
- R2: A window covers the raster position only when its enable bit is 1 and x0 <= x <= x1 and y0 <= y <= y1. Both corners are inclusive.
- R3: Format codes are 0 = RGB565 in bits 15:0, 1 = XRGB1555 in bits 14:0, 2 = XRGB8888 in bits 23:0 and 3 = ARGB1888 with the color in bits 23:0 and the alpha bit in bit 24. A 5-bit or 6-bit field widens to 8 bits by appending its own top bits below it.
- R4: Window 0 is always opaque. Its constant alpha, pixel-alpha select and key settings have no effect, and code 3 on window 0 displays bits 23:0 unchanged.
- R5: For windows 1 to 4, each channel becomes floor((a*upper + (15-a)*lower)/15). Here a is that channel's 4-bit alpha, packed {R,G,B} in bits 11:8, 7:4 and 3:0. With a = 15 the window's color shows exactly. With a = 0 the layer below shows exactly.
- R6: On windows 1 to 4, with code 3 and the pixel-alpha select set, every channel uses alpha 15 when bit 24 is 1 and alpha 0 when it is 0. Otherwise the constant alpha applies.
- R7: On windows 1 to 4 with the key enabled, the widened 24-bit color is compared with key bits 23:0, and key bits 31:24 are ignored. Direction 0 makes a matching pixel transparent. Direction 1 makes a non-matching pixel transparent.
- R8: A higher window index lies above a lower one. Layers are applied in order from window 0 to window 4.
- R9: A position that no enabled window covers outputs 0 (black). A partly transparent window with nothing below it blends over black.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| px_active_i | input | 1 | Raster position is inside the visible area |
| ras_x_i | input | COORD_W | Raster column |
| ras_y_i | input | COORD_W | Raster row |
| win_en_i | input | NUM_WIN | Per-window enable |
| win_x0_i | input | NUM_WIN x COORD_W | Left edge, inclusive |
| win_y0_i | input | NUM_WIN x COORD_W | Top edge, inclusive |
| win_x1_i | input | NUM_WIN x COORD_W | Right edge, inclusive |
| win_y1_i | input | NUM_WIN x COORD_W | Bottom edge, inclusive |
| win_fmt_i | input | NUM_WIN x 2 | Pixel format code |
| win_pxa_sel_i | input | NUM_WIN | Use the pixel alpha bit in format 3 |
| win_alpha_i | input | NUM_WIN x 12 | Constant alpha {R,G,B}, 4 bits each |
| key_en_i | input | NUM_WIN | Color-key enable |
| key_dir_i | input | NUM_WIN | Key direction: 0 match transparent, 1 mismatch transparent |
| key_val_i | input | NUM_WIN x KEY_W | Key color in bits 23:0 |
| win_pix_i | input | NUM_WIN x PIX_W | Window pixel at the raster position |
| out_valid_o | output | 1 | Output pixel is valid |
| out_rgb_o | output | 24 | Composite color {R,G,B} |

## Verification
A single full-screen base window exercises each format code with pure primaries and small values, which separates the bit-replication rules. Rectangles are probed exactly on and one step past each edge to tell inclusive corners from exclusive ones. Two-layer stacks are run at alpha 15, alpha 0 and mixed per-channel alphas. This distinguishes the exact blend formula from a shift or a swapped operand. Further runs with the key set to matching and non-matching colors in both directions, the per-pixel alpha bit in both states, and four overlapping opaque windows confirm transparency handling, per-pixel alpha and stacking order.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int CH_W    = 8;
    localparam int ALPHA_W = 4;
    localparam int AMAX    = (1 << ALPHA_W) - 1;
    localparam int SUM_W   = CH_W + ALPHA_W;
    localparam int RGB_W   = 3 * CH_W;
    localparam int ACFG_W  = 3 * ALPHA_W;
    localparam int ABIT    = RGB_W;

    typedef enum logic [1:0] {
        FMT_RGB565   = 2'd0,
        FMT_XRGB1555 = 2'd1,
        FMT_XRGB8888 = 2'd2,
        FMT_ARGB1888 = 2'd3
    } pix_fmt_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic [ALPHA_W-1:0] r;
        logic [ALPHA_W-1:0] g;
        logic [ALPHA_W-1:0] b;
    } alpha_t;

    // One channel of the weighted mix, exact division by the full-scale alpha.
    function automatic logic [CH_W-1:0] mix_ch(input logic [CH_W-1:0] up,
                                               input logic [CH_W-1:0] low,
                                               input logic [ALPHA_W-1:0] a);
        logic [SUM_W-1:0] acc;
        logic [ALPHA_W-1:0] inv;
        inv = ALPHA_W'(AMAX) - a;
        acc = SUM_W'(a) * SUM_W'(up) + SUM_W'(inv) * SUM_W'(low);
        return CH_W'(acc / SUM_W'(AMAX));
    endfunction

endpackage

// File: rtl/ovl_win_cover.sv
module ovl_win_cover #(
    parameter int COORD_W = 12
) (
    input  logic               en_i,
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    input  logic [COORD_W-1:0] x0_i,
    input  logic [COORD_W-1:0] y0_i,
    input  logic [COORD_W-1:0] x1_i,
    input  logic [COORD_W-1:0] y1_i,
    output logic               hit_o
);

    logic in_x;
    logic in_y;

    always_comb begin
        in_x  = (x_i >= x0_i) && (x_i <= x1_i);
        in_y  = (y_i >= y0_i) && (y_i <= y1_i);
        hit_o = en_i && in_x && in_y;
    end

endmodule

// File: rtl/ovl_pix_decode.sv
module ovl_pix_decode
    import ovl_pkg::*;
#(
    parameter int PIX_W   = 32,
    parameter int KEY_W   = 32,
    parameter bit IS_BASE = 1'b0
) (
    input  logic [PIX_W-1:0]  pix_i,
    input  logic [1:0]        fmt_i,
    input  logic              pxa_sel_i,
    input  logic [ACFG_W-1:0] alpha_cfg_i,
    input  logic              key_en_i,
    input  logic              key_dir_i,
    input  logic [KEY_W-1:0]  key_val_i,
    output rgb_t              color_o,
    output alpha_t            alpha_o
);

    pix_fmt_e fmt;
    rgb_t     wide;

    assign fmt = pix_fmt_e'(fmt_i);

    always_comb begin
        unique case (fmt)
            FMT_RGB565: begin
                wide.r = {pix_i[15:11], pix_i[15:13]};
                wide.g = {pix_i[10:5],  pix_i[10:9]};
                wide.b = {pix_i[4:0],   pix_i[4:2]};
            end
            FMT_XRGB1555: begin
                wide.r = {pix_i[14:10], pix_i[14:12]};
                wide.g = {pix_i[9:5],   pix_i[9:7]};
                wide.b = {pix_i[4:0],   pix_i[4:2]};
            end
            default: begin
                wide = pix_i[RGB_W-1:0];
            end
        endcase
    end

    assign color_o = wide;

    generate
        if (IS_BASE) begin : g_base
            // Base layer: always opaque, no keying, alpha bit dropped.
            assign alpha_o = '1;
            logic unused_base;
            assign unused_base = ^{pxa_sel_i, alpha_cfg_i, key_en_i, key_dir_i,
                                   key_val_i, pix_i};
        end else begin : g_upper
            logic   key_hit;
            logic   clear;
            alpha_t chosen;

            always_comb begin
                key_hit = (wide == key_val_i[RGB_W-1:0]);
                clear   = key_en_i && (key_dir_i ? !key_hit : key_hit);
                if (fmt == FMT_ARGB1888 && pxa_sel_i) begin
                    chosen = pix_i[ABIT] ? '1 : '0;
                end else begin
                    chosen = alpha_t'(alpha_cfg_i);
                end
                alpha_o = clear ? '0 : chosen;
            end

            logic unused_upper;
            assign unused_upper = ^{key_val_i, pix_i};
        end
    endgenerate

endmodule

// File: rtl/ovl_blend_stage.sv
module ovl_blend_stage
    import ovl_pkg::*;
(
    input  logic   hit_i,
    input  rgb_t   lower_i,
    input  rgb_t   upper_i,
    input  alpha_t alpha_i,
    output rgb_t   mix_o
);

    rgb_t blended;

    always_comb begin
        blended.r = mix_ch(upper_i.r, lower_i.r, alpha_i.r);
        blended.g = mix_ch(upper_i.g, lower_i.g, alpha_i.g);
        blended.b = mix_ch(upper_i.b, lower_i.b, alpha_i.b);
        mix_o     = hit_i ? blended : lower_i;
    end

endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
    import ovl_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int COORD_W = 12,
    parameter int PIX_W   = 32,
    parameter int KEY_W   = 32
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              px_active_i,
    input  logic [COORD_W-1:0]                ras_x_i,
    input  logic [COORD_W-1:0]                ras_y_i,
    input  logic [NUM_WIN-1:0]                win_en_i,
    input  logic [NUM_WIN-1:0][COORD_W-1:0]   win_x0_i,
    input  logic [NUM_WIN-1:0][COORD_W-1:0]   win_y0_i,
    input  logic [NUM_WIN-1:0][COORD_W-1:0]   win_x1_i,
    input  logic [NUM_WIN-1:0][COORD_W-1:0]   win_y1_i,
    input  logic [NUM_WIN-1:0][1:0]           win_fmt_i,
    input  logic [NUM_WIN-1:0]                win_pxa_sel_i,
    input  logic [NUM_WIN-1:0][11:0]          win_alpha_i,
    input  logic [NUM_WIN-1:0]                key_en_i,
    input  logic [NUM_WIN-1:0]                key_dir_i,
    input  logic [NUM_WIN-1:0][KEY_W-1:0]     key_val_i,
    input  logic [NUM_WIN-1:0][PIX_W-1:0]     win_pix_i,
    output logic                              out_valid_o,
    output logic [23:0]                       out_rgb_o
);

    rgb_t layer [NUM_WIN+1];
    assign layer[0] = '0;

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            logic   hit;
            rgb_t   color;
            alpha_t alpha;

            ovl_win_cover #(.COORD_W(COORD_W)) cover_i (
                .en_i (win_en_i[w]),
                .x_i  (ras_x_i),
                .y_i  (ras_y_i),
                .x0_i (win_x0_i[w]),
                .y0_i (win_y0_i[w]),
                .x1_i (win_x1_i[w]),
                .y1_i (win_y1_i[w]),
                .hit_o(hit)
            );

            ovl_pix_decode #(
                .PIX_W  (PIX_W),
                .KEY_W  (KEY_W),
                .IS_BASE(w == 0)
            ) decode_i (
                .pix_i      (win_pix_i[w]),
                .fmt_i      (win_fmt_i[w]),
                .pxa_sel_i  (win_pxa_sel_i[w]),
                .alpha_cfg_i(win_alpha_i[w]),
                .key_en_i   (key_en_i[w]),
                .key_dir_i  (key_dir_i[w]),
                .key_val_i  (key_val_i[w]),
                .color_o    (color),
                .alpha_o    (alpha)
            );

            ovl_blend_stage blend_i (
                .hit_i  (hit),
                .lower_i(layer[w]),
                .upper_i(color),
                .alpha_i(alpha),
                .mix_o  (layer[w+1])
            );
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_valid_o <= 1'b0;
            out_rgb_o   <= '0;
        end else begin
            out_valid_o <= px_active_i;
            out_rgb_o   <= px_active_i ? layer[NUM_WIN] : '0;
        end
    end

endmodule

// File: rtl/ovl_compositor_chk.sv
module ovl_compositor_chk #(
    parameter int NUM_WIN = 5,
    parameter int COORD_W = 12,
    parameter int PIX_W   = 32,
    parameter int KEY_W   = 32
) (
    input logic                              clk_i,
    input logic                              rst_ni,
    input logic                              px_active_i,
    input logic [COORD_W-1:0]                ras_x_i,
    input logic [COORD_W-1:0]                ras_y_i,
    input logic [NUM_WIN-1:0]                win_en_i,
    input logic [NUM_WIN-1:0][COORD_W-1:0]   win_x0_i,
    input logic [NUM_WIN-1:0][COORD_W-1:0]   win_y0_i,
    input logic [NUM_WIN-1:0][COORD_W-1:0]   win_x1_i,
    input logic [NUM_WIN-1:0][COORD_W-1:0]   win_y1_i,
    input logic [NUM_WIN-1:0][1:0]           win_fmt_i,
    input logic [NUM_WIN-1:0]                key_en_i,
    input logic [NUM_WIN-1:0]                key_dir_i,
    input logic [NUM_WIN-1:0][KEY_W-1:0]     key_val_i,
    input logic [NUM_WIN-1:0][PIX_W-1:0]     win_pix_i,
    input logic                              out_valid_o,
    input logic [23:0]                       out_rgb_o
);

    logic in_rect0;
    logic in_rect1;
    assign in_rect0 = ras_x_i >= win_x0_i[0] && ras_x_i <= win_x1_i[0] &&
                      ras_y_i >= win_y0_i[0] && ras_y_i <= win_y1_i[0];
    assign in_rect1 = ras_x_i >= win_x0_i[1] && ras_x_i <= win_x1_i[1] &&
                      ras_y_i >= win_y0_i[1] && ras_y_i <= win_y1_i[1];

    logic unused_chk;
    assign unused_chk = ^{key_en_i, key_dir_i, key_val_i, win_x0_i, win_y0_i,
                          win_x1_i, win_y1_i, win_fmt_i, win_pix_i};

    assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        px_active_i |=> out_valid_o);

    assert_idle_black_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !px_active_i |=> (!out_valid_o && out_rgb_o == 24'h0));

    assert_nothing_enabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (px_active_i && win_en_i == '0) |=> out_rgb_o == 24'h0);

    assert_base_opaque_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (px_active_i && win_en_i == NUM_WIN'(1) && win_fmt_i[0][1] && in_rect0)
        |=> out_rgb_o == $past(win_pix_i[0][23:0]));

    assert_key_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (px_active_i && win_en_i == NUM_WIN'(2) && in_rect1 && key_en_i[1] &&
         !key_dir_i[1] && win_fmt_i[1] == 2'd2 &&
         win_pix_i[1][23:0] == key_val_i[1][23:0])
        |=> out_rgb_o == 24'h0);

endmodule

bind ovl_compositor ovl_compositor_chk #(
    .NUM_WIN(NUM_WIN),
    .COORD_W(COORD_W),
    .PIX_W  (PIX_W),
    .KEY_W  (KEY_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .px_active_i(px_active_i),
    .ras_x_i    (ras_x_i),
    .ras_y_i    (ras_y_i),
    .win_en_i   (win_en_i),
    .win_x0_i   (win_x0_i),
    .win_y0_i   (win_y0_i),
    .win_x1_i   (win_x1_i),
    .win_y1_i   (win_y1_i),
    .win_fmt_i  (win_fmt_i),
    .key_en_i   (key_en_i),
    .key_dir_i  (key_dir_i),
    .key_val_i  (key_val_i),
    .win_pix_i  (win_pix_i),
    .out_valid_o(out_valid_o),
    .out_rgb_o  (out_rgb_o)
);

// File: tb/ovl_compositor_tb_top.sv
`timescale 1ns/1ps
module ovl_compositor_tb_top;

    localparam int NW = 5;
    localparam int CW = 12;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  px_active = 1'b0;
    logic [CW-1:0]         ras_x = '0;
    logic [CW-1:0]         ras_y = '0;
    logic [NW-1:0]         win_en = '0;
    logic [NW-1:0][CW-1:0] win_x0 = '0;
    logic [NW-1:0][CW-1:0] win_y0 = '0;
    logic [NW-1:0][CW-1:0] win_x1 = '0;
    logic [NW-1:0][CW-1:0] win_y1 = '0;
    logic [NW-1:0][1:0]    win_fmt = '0;
    logic [NW-1:0]         win_pxa = '0;
    logic [NW-1:0][11:0]   win_alpha = '0;
    logic [NW-1:0]         key_en = '0;
    logic [NW-1:0]         key_dir = '0;
    logic [NW-1:0][31:0]   key_val = '0;
    logic [NW-1:0][31:0]   win_pix = '0;
    logic                  out_valid;
    logic [23:0]           out_rgb;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ovl_compositor dut_i (
        .clk_i(clk), .rst_ni(rst_n), .px_active_i(px_active),
        .ras_x_i(ras_x), .ras_y_i(ras_y), .win_en_i(win_en),
        .win_x0_i(win_x0), .win_y0_i(win_y0), .win_x1_i(win_x1), .win_y1_i(win_y1),
        .win_fmt_i(win_fmt), .win_pxa_sel_i(win_pxa), .win_alpha_i(win_alpha),
        .key_en_i(key_en), .key_dir_i(key_dir), .key_val_i(key_val),
        .win_pix_i(win_pix), .out_valid_o(out_valid), .out_rgb_o(out_rgb)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic logic [23:0] m_expand(logic [1:0] f, logic [31:0] p);
        case (f)
            2'd0:    return {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
            2'd1:    return {p[14:10], p[14:12], p[9:5], p[9:7], p[4:0], p[4:2]};
            default: return p[23:0];
        endcase
    endfunction

    function automatic logic [7:0] m_mix(logic [7:0] up, logic [7:0] low, logic [3:0] a);
        int s;
        s = int'(a) * int'(up) + (15 - int'(a)) * int'(low);
        return 8'(s / 15);
    endfunction

    function automatic logic [23:0] m_compose();
        logic [23:0] acc = 24'h0;
        for (int w = 0; w < NW; w++) begin
            logic [23:0] c;
            logic [11:0] a;
            logic hit;
            hit = win_en[w] && ras_x >= win_x0[w] && ras_x <= win_x1[w] &&
                  ras_y >= win_y0[w] && ras_y <= win_y1[w];
            if (hit) begin
                c = m_expand(win_fmt[w], win_pix[w]);
                if (w == 0) a = 12'hFFF;
                else if (win_fmt[w] == 2'd3 && win_pxa[w]) a = win_pix[w][24] ? 12'hFFF : 12'h000;
                else a = win_alpha[w];
                if (w != 0 && key_en[w]) begin
                    if (key_dir[w] ? (c != key_val[w][23:0]) : (c == key_val[w][23:0])) a = 12'h000;
                end
                acc = {m_mix(c[23:16], acc[23:16], a[11:8]),
                       m_mix(c[15:8],  acc[15:8],  a[7:4]),
                       m_mix(c[7:0],   acc[7:0],   a[3:0])};
            end
        end
        return acc;
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(string tag, logic vexp, logic [23:0] exp);
        total++;
        if (out_valid !== vexp || out_rgb !== exp) begin
            bad++;
            $display("FAIL %s: got valid=%b rgb=%h, expected valid=%b rgb=%h",
                     tag, out_valid, out_rgb, vexp, exp);
        end
    endtask

    // Present a pixel at a negedge, check the registered result one clock later.
    task automatic probe(string tag, int x, int y, bit fixed = 0, logic [23:0] fexp = 0);
        logic [23:0] exp;
        px_active = 1'b1;
        ras_x = CW'(x);
        ras_y = CW'(y);
        exp = fixed ? fexp : m_compose();
        @(negedge clk);
        chk(tag, 1'b1, exp);
    endtask

    task automatic clear_all();
        win_en = '0; win_x0 = '0; win_y0 = '0; win_x1 = '0; win_y1 = '0;
        win_fmt = '0; win_pxa = '0; win_alpha = '0; key_en = '0;
        key_dir = '0; key_val = '0; win_pix = '0;
    endtask

    task automatic full_win(int w, logic [1:0] f, logic [31:0] p, logic [11:0] a);
        win_en[w] = 1'b1;
        win_x0[w] = '0; win_y0[w] = '0; win_x1[w] = '1; win_y1[w] = '1;
        win_fmt[w] = f; win_pix[w] = p; win_alpha[w] = a;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset outputs", 1'b0, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 1'b0, 24'h0);
    endtask

    task automatic t_latency();
        clear_all();
        full_win(0, 2'd2, 32'h00_123456, 12'h0);
        probe("R1 active pixel", 5, 5, 1, 24'h123456);
        px_active = 1'b0;
        @(negedge clk);
        chk("R1 inactive forces black", 1'b0, 24'h0);
    endtask

    task automatic t_bounds();
        clear_all();
        win_en[0] = 1'b1; win_fmt[0] = 2'd2; win_pix[0] = 32'h00_A0B0C0;
        win_x0[0] = 10; win_y0[0] = 20; win_x1[0] = 30; win_y1[0] = 40;
        probe("R2 top-left corner inside", 10, 20, 1, 24'hA0B0C0);
        probe("R2 bottom-right corner inside", 30, 40, 1, 24'hA0B0C0);
        probe("R2 left of rect", 9, 25, 1, 24'h0);
        probe("R2 right of rect", 31, 25, 1, 24'h0);
        probe("R2 below rect", 15, 41, 1, 24'h0);
        win_en[0] = 1'b0;
        probe("R2 disabled window", 15, 25, 1, 24'h0);
    endtask

    task automatic t_formats();
        clear_all();
        full_win(0, 2'd0, 32'h0000_F800, 12'h0);
        probe("R3 565 red", 1, 1, 1, 24'hFF0000);
        win_pix[0] = 32'h0000_07E0;
        probe("R3 565 green", 1, 1, 1, 24'h00FF00);
        win_fmt[0] = 2'd1; win_pix[0] = 32'h0000_7C00;
        probe("R3 1555 red", 1, 1, 1, 24'hFF0000);
        win_pix[0] = 32'h0000_0421;
        probe("R3 1555 low bits", 1, 1, 1, 24'h080808);
        win_fmt[0] = 2'd2; win_pix[0] = 32'hFF_13579B;
        probe("R3 8888 upper byte ignored", 1, 1, 1, 24'h13579B);
    endtask

    task automatic t_base_opaque();
        clear_all();
        full_win(0, 2'd3, 32'h00_445566, 12'h000);
        win_pxa[0] = 1'b1;
        key_en[0] = 1'b1; key_val[0] = 32'h00_445566;
        probe("R4 base alpha bit 0 still opaque", 2, 2, 1, 24'h445566);
        key_dir[0] = 1'b1; win_pix[0] = 32'h01_778899;
        probe("R4 base key and alpha ignored", 2, 2, 1, 24'h778899);
    endtask

    task automatic t_alpha();
        clear_all();
        full_win(0, 2'd2, 32'h00_204060, 12'h0);
        full_win(1, 2'd2, 32'h00_E0C0A0, 12'hFFF);
        probe("R5 alpha 15 shows upper", 3, 3, 1, 24'hE0C0A0);
        win_alpha[1] = 12'h000;
        probe("R5 alpha 0 shows lower", 3, 3, 1, 24'h204060);
        win_alpha[1] = 12'h840;
        probe("R5 per-channel mix", 3, 3, 1, 24'h866260);
        win_alpha[1] = 12'h5A3;
        probe("R5 mixed alphas model", 3, 3);
    endtask

    task automatic t_pixalpha();
        clear_all();
        full_win(0, 2'd2, 32'h00_101010, 12'h0);
        full_win(1, 2'd3, 32'h01_F0E0D0, 12'h000);
        win_pxa[1] = 1'b1;
        probe("R6 pixel alpha bit 1 opaque", 4, 4, 1, 24'hF0E0D0);
        win_pix[1] = 32'h00_F0E0D0; win_alpha[1] = 12'hFFF;
        probe("R6 pixel alpha bit 0 transparent", 4, 4, 1, 24'h101010);
        win_pxa[1] = 1'b0; win_alpha[1] = 12'h555;
        probe("R6 select off uses constant", 4, 4);
    endtask

    task automatic t_key();
        clear_all();
        full_win(0, 2'd2, 32'h00_0A0B0C, 12'h0);
        full_win(1, 2'd2, 32'h00_AABBCC, 12'hFFF);
        key_en[1] = 1'b1; key_val[1] = 32'h77_AABBCC;
        probe("R7 dir0 match transparent", 6, 6, 1, 24'h0A0B0C);
        win_pix[1] = 32'h00_AABBCD;
        probe("R7 dir0 mismatch shows", 6, 6, 1, 24'hAABBCD);
        key_dir[1] = 1'b1;
        probe("R7 dir1 mismatch transparent", 6, 6, 1, 24'h0A0B0C);
        win_pix[1] = 32'h00_AABBCC;
        probe("R7 dir1 match shows", 6, 6, 1, 24'hAABBCC);
        win_en[0] = 1'b0; key_dir[1] = 1'b0;
        probe("R7 keyed over nothing is black", 6, 6, 1, 24'h0);
    endtask

    task automatic t_priority();
        clear_all();
        full_win(0, 2'd2, 32'h00_000001, 12'h0);
        for (int w = 1; w < NW; w++) full_win(w, 2'd2, 32'(w * 32'h111111), 12'hFFF);
        probe("R8 top window wins", 7, 7, 1, 24'h444444);
        win_en[4] = 1'b0;
        probe("R8 next window down", 7, 7, 1, 24'h333333);
        win_en[3] = 1'b0; win_alpha[2] = 12'h777;
        probe("R8 mid window blends over lower", 7, 7);
    endtask

    task automatic t_uncovered();
        clear_all();
        win_en = '1;
        for (int w = 0; w < NW; w++) begin
            win_x0[w] = 100; win_y0[w] = 100; win_x1[w] = 120; win_y1[w] = 120;
            win_fmt[w] = 2'd2; win_pix[w] = 32'h00_FFFFFF; win_alpha[w] = 12'hFFF;
        end
        probe("R9 outside all windows", 50, 50, 1, 24'h0);
        clear_all();
        full_win(2, 2'd2, 32'h00_F0F0F0, 12'h888);
        probe("R9 blend over black", 8, 8, 1, 24'h808080);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_bounds();
        t_formats();
        t_base_opaque();
        t_alpha();
        t_pixalpha();
        t_key();
        t_priority();
        t_uncovered();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule